// File: doc/BRIEF.md
# Hand-Clocked Ripple Counter with Scrambled Output Order

The block counts hand-made clock pulses and presents them as a fixed but scrambled 3-bit sequence. A two-contact clock source holds the clock level in a set/clear latch. One contact drives the clock high and the other drives it low, and the level stays where it was put between touches. Every rising clock edge advances a 3-bit binary counter. The counter is a ripple chain of D flip-flops, each wired to toggle: only the first stage sees the generated clock, and every later stage is clocked from the stage below it.

A purely combinational decode stage maps each binary count onto an output code. As the counter steps 0 through 7, the outputs run through 3, 0, 1, 6, 7, 4, 5, 2, and the cycle repeats for as long as pulses arrive. Both the raw count and the decoded code are visible at the ports. An active-low asynchronous clear puts the block into a known state.

Top module: `ripple_seq_counter`

## Requirements
- R1: While `rst_n` is low, the count is 000 and the internal clock level is low. The decoded output is therefore 3 (binary 011) until the first rising clock edge.
- R2: Each low-to-high transition of the internal clock increases `cnt_q` by exactly one, and 7 wraps to 0.
- R3: Counter bit 0 toggles on every rising clock edge. Each higher bit i toggles exactly when bit i-1 falls from 1 to 0, and at no other time.
- R4: `seq_q` (bit 2 is the most significant) equals 3, 0, 1, 6, 7, 4, 5, 2 for counts 0, 1, 2, 3, 4, 5, 6, 7 respectively.
- R5: `seq_q[0]` is the complement of `cnt_q[0]`.
- R6: `seq_q[1]` is 1 when `cnt_q[1]` equals `cnt_q[0]`, and 0 when they differ.
- R7: `seq_q[2]` is 1 for counts 3, 4, 5 and 6, and 0 for counts 0, 1, 2 and 7.
- R8: A pulse on `tap_hi` drives the internal clock high and a pulse on `tap_lo` drives it low, with the level held between pulses. A second `tap_hi` pulse while the clock is already high leaves the count unchanged.
- R9: When `tap_hi` and `tap_lo` are high together, the clock is forced low. This produces no count step if the clock was low, and it means the next lone `tap_hi` pulse does produce a step if the clock was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous clear of the counter and the clock latch |
| tap_hi | input | 1 | Contact that drives the internal clock high |
| tap_lo | input | 1 | Contact that drives the internal clock low; dominates `tap_hi` |
| cnt_q | output | 3 | Raw binary count |
| seq_q | output | 3 | Decoded out-of-order code |

## Verification
The two functions that can fall in the same cycle are the clock latch's set and clear: both contacts can be touched at once. The bench provokes this in directed tests with the clock resting low and with it resting high, and again in the random mix, where it raises and drops both contacts in the same step. The verdict rests only on the count at the ports. With the clock low, a correct block shows no step. With the clock high, it shows no step on the double touch and exactly one step on the following lone high touch, which proves that the clock level went low.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  // Width of the count; the output remap is defined for exactly three bits.
  localparam int unsigned CNT_W = 3;
  localparam int unsigned N_CODES = 1 << CNT_W;

  typedef logic [CNT_W-1:0] cnt_t;

  // Remap of a binary count onto the scrambled output code.
  function automatic cnt_t remap_code(input cnt_t c);
    cnt_t r;
    r[0] = ~c[0];
    r[1] = ~(c[1] ^ c[0]);
    r[2] = c[2] ^ (c[1] & c[0]);
    return r;
  endfunction
endpackage

// File: rtl/rsc_clock_latch.sv
module rsc_clock_latch (
  input  logic rst_n,
  input  logic hi_touch,
  input  logic lo_touch,
  output logic clk_lvl
);
  // Level-holding set/clear cell; clear and reset dominate set.
  always_latch begin
    if (!rst_n || lo_touch) begin
      clk_lvl <= 1'b0;
    end else if (hi_touch) begin
      clk_lvl <= 1'b1;
    end
  end
endmodule

// File: rtl/rsc_toggle_stage.sv
module rsc_toggle_stage (
  input  logic rst_n,
  input  logic stage_clk,
  output logic q,
  output logic q_n
);
  logic d_fb;

  assign q_n  = ~q;
  assign d_fb = q_n;

  always_ff @(posedge stage_clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= d_fb;
    end
  end
endmodule

// File: rtl/rsc_decoder.sv
module rsc_decoder
  import rsc_pkg::*;
(
  input  cnt_t count,
  output cnt_t code
);
  assign code = remap_code(count);
endmodule

// File: rtl/ripple_seq_counter.sv
module ripple_seq_counter
  import rsc_pkg::*;
(
  input  logic             rst_n,
  input  logic             tap_hi,
  input  logic             tap_lo,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] seq_q
);
  logic             man_clk;
  logic [CNT_W-1:0] stage_q;
  logic [CNT_W-1:0] stage_qn;
  logic [CNT_W-1:0] stage_clk;

  rsc_clock_latch u_latch (
    .rst_n    (rst_n),
    .hi_touch (tap_hi),
    .lo_touch (tap_lo),
    .clk_lvl  (man_clk)
  );

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stage_clk[i] = man_clk;
    end else begin : g_chain
      // Rising edge of the previous inverted output, i.e. the previous bit falling.
      assign stage_clk[i] = stage_qn[i-1];
    end

    rsc_toggle_stage u_tff (
      .rst_n     (rst_n),
      .stage_clk (stage_clk[i]),
      .q         (stage_q[i]),
      .q_n       (stage_qn[i])
    );
  end

  assign cnt_q = stage_q;

  rsc_decoder u_dec (
    .count (stage_q),
    .code  (seq_q)
  );
endmodule

// File: rtl/ripple_seq_counter_chk.sv
module ripple_seq_counter_chk
  import rsc_pkg::*;
(
  input logic             rst_n,
  input logic             mclk,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] seq_q
);
  // Successor of an output code in the repeating order.
  function automatic cnt_t next_code(input cnt_t s);
    case (s)
      3'd3:    return 3'd0;
      3'd0:    return 3'd1;
      3'd1:    return 3'd6;
      3'd6:    return 3'd7;
      3'd7:    return 3'd4;
      3'd4:    return 3'd5;
      3'd5:    return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  logic seen_edge;
  cnt_t prev_cnt;
  cnt_t prev_seq;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      seen_edge <= 1'b0;
      prev_cnt  <= '0;
      prev_seq  <= '0;
    end else begin
      seen_edge <= 1'b1;
      prev_cnt  <= cnt_q;
      prev_seq  <= seq_q;
    end
  end

  a_r1_reset_clear: assert property (@(posedge rst_n)
    1'b1 |-> (cnt_q == '0) && (seq_q == 3'd3));

  a_r2_count_step: assert property (@(posedge mclk) disable iff (!rst_n)
    seen_edge |-> cnt_q == cnt_t'(prev_cnt + 1'b1));

  a_r4_seq_successor: assert property (@(posedge mclk) disable iff (!rst_n)
    seen_edge |-> seq_q == next_code(prev_seq));

  for (genvar i = 1; i < CNT_W; i++) begin : g_tog
    logic seen_fall;
    logic prev_bit;

    always_ff @(negedge cnt_q[i-1] or negedge rst_n) begin
      if (!rst_n) begin
        seen_fall <= 1'b0;
        prev_bit  <= 1'b0;
      end else begin
        seen_fall <= 1'b1;
        prev_bit  <= cnt_q[i];
      end
    end

    a_r3_stage_toggle: assert property (@(negedge cnt_q[i-1]) disable iff (!rst_n)
      seen_fall |-> cnt_q[i] != prev_bit);
  end
endmodule

bind ripple_seq_counter ripple_seq_counter_chk u_chk (
  .rst_n (rst_n),
  .mclk  (man_clk),
  .cnt_q (cnt_q),
  .seq_q (seq_q)
);

// File: tb/test_ripple_seq_counter.sv
module test_ripple_seq_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tap_hi = 1'b0;
  logic       tap_lo = 1'b0;
  logic [2:0] cnt_q;
  logic [2:0] seq_q;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  logic       m_clk = 1'b0;
  logic [2:0] m_cnt = 3'd0;

  always #10 clk = ~clk;

  ripple_seq_counter i_ripple_seq_counter (
    .rst_n  (rst_n),
    .tap_hi (tap_hi),
    .tap_lo (tap_lo),
    .cnt_q  (cnt_q),
    .seq_q  (seq_q)
  );

  // Expected code listed directly as the required order.
  function automatic logic [2:0] exp_code(input logic [2:0] c);
    logic [2:0] lut [8] = '{3'd3, 3'd0, 3'd1, 3'd6, 3'd7, 3'd4, 3'd5, 3'd2};
    return lut[c];
  endfunction

  function automatic logic exp_top(input logic [2:0] c);
    return (c >= 3'd3) && (c <= 3'd6);
  endfunction

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R2 R3 count"}, cnt_q, m_cnt);
    chk({ctx, " R4 code"}, seq_q, exp_code(m_cnt));
    chk({ctx, " R5 bit0"}, {2'b0, seq_q[0]}, {2'b0, ~m_cnt[0]});
    chk({ctx, " R6 bit1"}, {2'b0, seq_q[1]}, {2'b0, m_cnt[1] == m_cnt[0]});
    chk({ctx, " R7 bit2"}, {2'b0, seq_q[2]}, {2'b0, exp_top(m_cnt)});
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic touch(input logic hi, input logic lo);
    @(negedge clk);
    tap_hi = hi;
    tap_lo = lo;
    @(negedge clk);
    tap_hi = 1'b0;
    tap_lo = 1'b0;
    if (lo) begin
      m_clk = 1'b0;
    end else if (hi && !m_clk) begin
      m_clk = 1'b1;
      m_cnt = m_cnt + 3'd1;
    end
    settle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_clk = 1'b0;
    m_cnt = 3'd0;
    settle();
    chk("R1 count in reset", cnt_q, 3'd0);
    chk("R1 code in reset", seq_q, 3'd3);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    settle();
    do_reset();
    check_all("after reset");

    // Sixteen full manual pulses: two complete passes of the order.
    for (int k = 0; k < 16; k++) begin
      touch(1'b1, 1'b0);
      check_all("pulse");
      touch(1'b0, 1'b1);
      check_all("release");
    end

    // R8: a repeated high touch while already high adds no step.
    touch(1'b1, 1'b0);
    touch(1'b1, 1'b0);
    check_all("R8 repeated high");
    touch(1'b0, 1'b1);

    // R9: both contacts with clock low must not step.
    touch(1'b1, 1'b1);
    check_all("R9 both while low");
    // R9: both contacts with clock high force it low; the next high touch steps.
    touch(1'b1, 1'b0);
    touch(1'b1, 1'b1);
    check_all("R9 both while high");
    touch(1'b1, 1'b0);
    check_all("R9 step after forced low");

    // R1: clear in mid-count.
    do_reset();
    check_all("R1 mid-count clear");

    // Random mix of touches, double touches and rare clears.
    for (int k = 0; k < 400; k++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r < 7) begin
        touch(1'b1, 1'b0);
      end else if (r < 12) begin
        touch(1'b0, 1'b1);
      end else if (r < 15) begin
        touch(1'b1, 1'b1);
      end else begin
        do_reset();
      end
      check_all("random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule